// File: doc/BRIEF.md
# UART DMA Ready Status Generator

This block derives the two DMA pacing flags of a 16550-style UART, transmit-ready and receive-ready, from the occupancy of the transmit and receive storage. It also derives the active-low interrupt-pending flag from the interrupt sources and their enables. It has no FIFOs of its own. It takes the character counts that the surrounding UART already keeps, a one-cycle character time-out pulse, a two-bit receive trigger select and two mode bits: DMA select and FIFO enable.

Two signalling modes exist. The simple mode reports plain occupancy. The burst mode is used only when both mode bits are set. In burst mode the transmit flag goes high once the transmit FIFO fills and stays high until the FIFO drains. The receive flag drops when the trigger level is reached or a time-out occurs, and it stays low until the receive FIFO is empty. Every output is a register, so it follows its inputs at the next clock edge. All outputs reset high.

Top module: `dma_rdy_status`

## Requirements
- R1: While reset is asserted (rst_n low), tx_rdy, rx_rdy and irq_n are all 1.
- R2: In simple mode, tx_rdy is 1 after a clock edge at which tx_count was nonzero and 0 after an edge at which tx_count was 0. This holds whatever the value of fifo_en.
- R3: Burst mode applies only when dma_sel=1 and fifo_en=1. With dma_sel=1 and fifo_en=0 the block behaves exactly as in simple mode.
- R4: In burst mode, tx_rdy becomes 0 after an edge with tx_count=0 and becomes 1 after an edge with tx_count=DEPTH. For any other count it keeps its value.
- R5: In simple mode, rx_rdy is 1 after an edge with rx_count=0 and 0 after an edge with rx_count nonzero.
- R6: In burst mode, rx_rdy becomes 0 after an edge with rx_count nonzero and either rx_timeout=1 or rx_count at or above the trigger level. It becomes 1 after an edge with rx_count=0. Otherwise it keeps its value.
- R7: The trigger level is set by trig_sel: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters.
- R8: In burst mode, when rx_timeout=1 and rx_count=0 at the same edge, rx_rdy becomes 1, because the empty condition wins.
- R9: irq_n is 0 after an edge at which some bit k has irq_src[k]=1 and irq_en[k]=1. Otherwise it is 1; in particular it is 1 whenever irq_en is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_sel | input | 1 | DMA mode select |
| fifo_en | input | 1 | FIFO enable |
| trig_sel | input | 2 | Receive trigger level select |
| tx_count | input | CW | Characters held in the transmit FIFO or holding register |
| rx_count | input | CW | Characters held in the receive FIFO or holding register |
| rx_timeout | input | 1 | Character time-out pulse |
| irq_src | input | NSRC | Raw interrupt source flags |
| irq_en | input | NSRC | Per-source interrupt enables |
| tx_rdy | output | 1 | Transmit DMA ready flag |
| rx_rdy | output | 1 | Receive DMA ready flag |
| irq_n | output | 1 | Interrupt pending, active low |

CW = $clog2(DEPTH+1). The defaults are DEPTH=16, which gives CW=5, and NSRC=4.

## Verification
In burst mode the character time-out and the empty-FIFO condition can arrive at the same edge. The same holds for the time-out and a count at or above the trigger level. The bench sweeps every mode combination and every trigger select over one rising and then falling occupancy ramp. It pulses the time-out at a count of 2, where it competes with the trigger level, and at a count of 0, where it competes with the empty condition. Each edge is judged against a bench model built from the set and clear rules, in which a count of zero always wins.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;
   // receive trigger level for each select code
   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         2'b00:   trig_level = 1;
         2'b01:   trig_level = 4;
         2'b10:   trig_level = 8;
         default: trig_level = 14;
      endcase
   endfunction
endpackage

// File: rtl/tx_rdy_gen.sv
module tx_rdy_gen #(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          burst,
   input  logic [CW-1:0] count,
   output logic          rdy
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic empty;
   logic full;
   logic rdy_nxt;

   assign empty = (count == '0);
   assign full  = (count == FULL);

   always_comb begin
      if (!burst)     rdy_nxt = !empty;
      else if (empty) rdy_nxt = 1'b0;
      else if (full)  rdy_nxt = 1'b1;
      else            rdy_nxt = rdy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy <= 1'b1;
      else        rdy <= rdy_nxt;
   end
endmodule

// File: rtl/rx_rdy_gen.sv
module rx_rdy_gen #(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          burst,
   input  logic [1:0]    trig_sel,
   input  logic          timeout,
   input  logic [CW-1:0] count,
   output logic          rdy
);
   import dma_rdy_pkg::*;

   logic          empty;
   logic          at_trig;
   logic [CW-1:0] level;
   logic          rdy_nxt;

   assign level   = CW'(trig_level(trig_sel));
   assign empty   = (count == '0);
   assign at_trig = (count >= level);

   always_comb begin
      if (!burst)                  rdy_nxt = empty;
      else if (empty)              rdy_nxt = 1'b1;
      else if (timeout || at_trig) rdy_nxt = 1'b0;
      else                         rdy_nxt = rdy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy <= 1'b1;
      else        rdy <= rdy_nxt;
   end
endmodule

// File: rtl/irq_pend_gen.sv
module irq_pend_gen #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic [NSRC-1:0] en,
   output logic            pend_n
);
   logic [NSRC-1:0] live;

   for (genvar k = 0; k < NSRC; k++) begin : g_mask
      assign live[k] = src[k] & en[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_n <= 1'b1;
      else        pend_n <= ~|live;
   end
endmodule

// File: rtl/dma_rdy_status.sv
module dma_rdy_status #(
   parameter int DEPTH = 16,
   parameter int NSRC  = 4,
   parameter int CW    = $clog2(DEPTH+1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dma_sel,
   input  logic            fifo_en,
   input  logic [1:0]      trig_sel,
   input  logic [CW-1:0]   tx_count,
   input  logic [CW-1:0]   rx_count,
   input  logic            rx_timeout,
   input  logic [NSRC-1:0] irq_src,
   input  logic [NSRC-1:0] irq_en,
   output logic            tx_rdy,
   output logic            rx_rdy,
   output logic            irq_n
);
   if (DEPTH < 14) begin : g_bad_depth
      $error("DEPTH must cover the highest trigger level of 14");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("NSRC must be at least 1");
   end

   logic burst;
   assign burst = dma_sel & fifo_en;

   tx_rdy_gen #(.DEPTH(DEPTH), .CW(CW)) tx_i (
      .clk(clk), .rst_n(rst_n), .burst(burst), .count(tx_count), .rdy(tx_rdy)
   );

   rx_rdy_gen #(.DEPTH(DEPTH), .CW(CW)) rx_i (
      .clk(clk), .rst_n(rst_n), .burst(burst), .trig_sel(trig_sel),
      .timeout(rx_timeout), .count(rx_count), .rdy(rx_rdy)
   );

   irq_pend_gen #(.NSRC(NSRC)) irq_i (
      .clk(clk), .rst_n(rst_n), .src(irq_src), .en(irq_en), .pend_n(irq_n)
   );
endmodule

// File: rtl/dma_rdy_status_chk.sv
module dma_rdy_status_chk #(
   parameter int DEPTH = 16,
   parameter int NSRC  = 4,
   parameter int CW    = $clog2(DEPTH+1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dma_sel,
   input logic            fifo_en,
   input logic [1:0]      trig_sel,
   input logic [CW-1:0]   tx_count,
   input logic [CW-1:0]   rx_count,
   input logic            rx_timeout,
   input logic [NSRC-1:0] irq_src,
   input logic [NSRC-1:0] irq_en,
   input logic            tx_rdy,
   input logic            rx_rdy,
   input logic            irq_n
);
   logic [CW-1:0] lvl;
   always_comb begin
      unique case (trig_sel)
         2'b00: lvl = CW'(1);
         2'b01: lvl = CW'(4);
         2'b10: lvl = CW'(8);
         2'b11: lvl = CW'(14);
         default: lvl = CW'(14);
      endcase
   end

   logic two_bits;
   assign two_bits = dma_sel && fifo_en;

   // R2 R3: simple-mode transmit flag follows occupancy
   a_r2_tx_simple: assert property (@(posedge clk) disable iff (!rst_n)
      !two_bits |=> (tx_rdy == ($past(tx_count) != '0)));

   // R4: burst-mode transmit flag holds between empty and full
   a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      two_bits && tx_count != '0 && tx_count != CW'(DEPTH) |=> $stable(tx_rdy));

   // R5: simple-mode receive flag
   a_r5_rx_simple: assert property (@(posedge clk) disable iff (!rst_n)
      !two_bits |=> (rx_rdy == ($past(rx_count) == '0)));

   // R6 R7: burst-mode receive flag clears at trigger or time-out
   a_r6_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      two_bits && rx_count != '0 && (rx_timeout || rx_count >= lvl) |=> !rx_rdy);

   // R8: empty wins
   a_r8_empty_wins: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count == '0 |=> rx_rdy);

   // R9: nothing enabled and raised means no pending indication
   a_r9_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_src & irq_en) == '0 |=> irq_n);

   a_r9_irq_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_src & irq_en) != '0 |=> !irq_n);
endmodule

bind dma_rdy_status dma_rdy_status_chk #(.DEPTH(DEPTH), .NSRC(NSRC), .CW(CW)) chk_i (.*);

// File: tb/dma_rdy_status_tb_top.sv
module dma_rdy_status_tb_top;
   localparam int DEPTH = 16;
   localparam int NSRC  = 4;
   localparam int CW    = $clog2(DEPTH+1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            dma_sel = 1'b0;
   logic            fifo_en = 1'b0;
   logic [1:0]      trig_sel = 2'b00;
   logic [CW-1:0]   tx_count = '0;
   logic [CW-1:0]   rx_count = '0;
   logic            rx_timeout = 1'b0;
   logic [NSRC-1:0] irq_src = '0;
   logic [NSRC-1:0] irq_en = '0;
   logic            tx_rdy, rx_rdy, irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_rdy_status #(.DEPTH(DEPTH), .NSRC(NSRC)) dut_i (.*);

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int lvl_of(input int s);
      // R7 encoding
      return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
   endfunction

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic exp_tx, exp_rx, exp_irq, burst;
      int c, lv;
      string ttag, rtag;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 tx_rdy", tx_rdy, 1'b1);
      chk("R1 rx_rdy", rx_rdy, 1'b1);
      chk("R1 irq_n", irq_n, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      exp_tx = 1'b1;
      exp_rx = 1'b1;
      for (int m = 0; m < 4; m++) begin
         for (int t = 0; t < 4; t++) begin
            for (int i = 0; i <= 32; i++) begin
               c = (i <= 16) ? i : 32 - i;
               @(negedge clk);
               dma_sel    = m[1];
               fifo_en    = m[0];
               trig_sel   = t[1:0];
               tx_count   = CW'(c);
               rx_count   = CW'(c);
               rx_timeout = (i == 0 || i == 2 || i == 32);
               burst = dma_sel & fifo_en;
               lv = lvl_of(t);
               if (!burst) begin
                  exp_tx = (c != 0);
                  exp_rx = (c == 0);
                  ttag = (dma_sel) ? "R3 tx" : "R2 tx";
                  rtag = (dma_sel) ? "R3 rx" : "R5 rx";
               end else begin
                  ttag = "R4 tx";
                  if (c == 0) exp_tx = 1'b0;
                  else if (c == DEPTH) exp_tx = 1'b1;
                  if (c == 0) begin
                     exp_rx = 1'b1;
                     rtag = rx_timeout ? "R8 rx" : "R6 rx";
                  end else if (rx_timeout || c >= lv) begin
                     exp_rx = 1'b0;
                     rtag = (c == lv) ? "R7 rx" : "R6 rx";
                  end else rtag = "R6 rx";
               end
               @(posedge clk);
               #1;
               chk(ttag, tx_rdy, exp_tx);
               chk(rtag, rx_rdy, exp_rx);
            end
         end
      end
      @(negedge clk);
      rx_timeout = 1'b0;
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         irq_src = v[3:0];
         irq_en  = v[7:4];
         exp_irq = ((v[3:0] & v[7:4]) == 0);
         @(posedge clk);
         #1;
         chk("R9 irq_n", irq_n, exp_irq);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule